// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block connects a 32-bit internal master to an external bus whose devices can be 8, 16 or 32 bits wide. The master issues one operand request (byte, word or long word) at any byte address. The block runs as many external cycles as the operand needs, and the internal interface does not change with the width of the device that answers.

Each external cycle stays open until the device returns a two-bit active-low acknowledge. The acknowledge ends the cycle and also reports the device's width, so the width is learned again on every cycle. From that width and the current address, the block works out how many bytes moved and which byte lanes carried them. It then advances the address, reduces the byte count and, if bytes remain, starts another cycle after one idle clock. Read bytes are collected big-endian and right-justified in the read-data register. Write bytes are placed on every lane that any device width could read.

Top module: `bus_sizer`

## Requirements
- R1: After reset, the strobe is low, the done pulse is low and the read data is zero.
- R2: While the strobe is high and the acknowledge is 11 (wait), the strobe, address, size code and write data stay unchanged and done stays low.
- R3: The acknowledge codes are 00 for a 32-bit port, 01 for a 16-bit port and 10 for an 8-bit port. An aligned long word to a 32-bit port takes one cycle, and done follows two clocks after the request clock.
- R4: On a 16-bit port, each cycle moves at most two bytes on lanes 0 and 1. A byte at an odd address uses lane 1. An aligned long word takes two cycles at addresses A and A+2.
- R5: On an 8-bit port, each cycle moves one byte on lane 0, and the address advances by one after each cycle.
- R6: The external size code gives the bytes still to move: 01 means one, 10 means two, 11 means three, 00 means four. Requests use the same codes: 01 byte, 10 word, 00 long word.
- R7: Read data is big-endian: the lowest address lands in the most significant used byte of the result, and the result is right-justified with the unused upper bytes zero. Lane 0 is bits 31:24 and lane 3 is bits 7:0.
- R8: During a write cycle, each operand byte is driven on lane A[1:0] (32-bit view), on lane A[0] (16-bit view) and, for the first byte of the cycle, on lane 0 (8-bit view). Any device width therefore finds its bytes.
- R9: A misaligned access to a 32-bit port moves bytes only up to the next 4-byte boundary in one cycle. The rest goes in a following cycle.
- R10: The strobe drops in the clock after each acknowledge, and done is a one-clock pulse issued only after the final acknowledge.
- R11: The port width may differ from one cycle to the next within one operand, and each cycle follows the width reported for that cycle.
- R12: A request that arrives while a transfer is in progress is ignored, including one that arrives in the same clock as the final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Starts an operand transfer when the block is idle |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand size: 01 byte, 10 word, 00 long word |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 32 | Right-justified write operand |
| rsp_rdata | output | 32 | Right-justified, assembled read operand |
| rsp_done | output | 1 | One-clock pulse when the operand is complete |
| ext_addr | output | ADDR_W | Address of the current external cycle |
| ext_size | output | 2 | Bytes still to move |
| ext_strobe | output | 1 | External cycle active |
| ext_write | output | 1 | Direction of the external cycle |
| ext_wdata | output | 32 | Lane-replicated write data |
| ext_rdata | input | 32 | Read data from the external device |
| ext_ack_n | input | 2 | Active-low acknowledge and port-width code |

## Verification
A new request can arrive in the same clock that the final acknowledge of the current operand is sampled. In that clock, ending the transfer and accepting a new one compete. The bench holds a request with a different address high for the whole of a four-cycle byte-port read, including the acknowledge clock. It then checks that every external address belongs to the first operand and that no strobe appears in the clocks after done. A second overlap is a wait acknowledge during a cycle that is then reported at a new width. This is judged from the logged cycle addresses, the size codes and the measured latency.

// File: rtl/bus_sizer.sv
module bus_sizer #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [1:0]        ext_size,
  output logic              ext_strobe,
  output logic              ext_write,
  output logic [31:0]       ext_wdata,
  input  logic [31:0]       ext_rdata,
  input  logic [1:0]        ext_ack_n
);
  typedef enum logic [1:0] {S_IDLE, S_BUS, S_GAP} state_t;

  state_t            st;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        rem_q, tot_q;
  logic              wr_q, done_q;
  logic [31:0]       wop_q, rd_q, rd_nx, wd;
  logic [2:0]        n3, tot_in;
  logic              acked, last;
  int                a2, rem, tot, sent, pb, pw, n;

  assign tot_in = (req_size == 2'b00) ? 3'd4 : {1'b0, req_size};
  assign acked  = (st == S_BUS) && (ext_ack_n != 2'b11);

  always_comb begin
    a2   = int'(addr_q[1:0]);
    rem  = int'(rem_q);
    tot  = int'(tot_q);
    sent = tot - rem;
    case (ext_ack_n)
      2'b00:   begin pw = 4; pb = a2;     end
      2'b01:   begin pw = 2; pb = a2 % 2; end
      default: begin pw = 1; pb = 0;      end
    endcase
    n = (rem < pw - pb) ? rem : pw - pb;
    rd_nx = rd_q;
    for (int j = 0; j < 4; j++)
      if (j < n)
        rd_nx[8*(tot-1-sent-j) +: 8] = ext_rdata[8*(3-pb-j) +: 8];
    wd = '0;
    for (int p = 0; p < 3; p++) begin
      int b, r, c;
      b = (p == 0) ? 0 : (p == 1) ? a2 % 2 : a2;
      r = (p == 0) ? 1 : (p == 1) ? 2 - a2 % 2 : 4 - a2;
      c = (rem < r) ? rem : r;
      for (int j = 0; j < 4; j++)
        if (j < c)
          wd[8*(3-b-j) +: 8] = wop_q[8*(tot-1-sent-j) +: 8];
    end
  end

  assign n3   = 3'(n);
  assign last = acked && (rem_q == n3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      tot_q  <= '0;
      wr_q   <= 1'b0;
      wop_q  <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      case (st)
        S_IDLE:
          if (req_valid) begin
            st     <= S_BUS;
            addr_q <= req_addr;
            rem_q  <= tot_in;
            tot_q  <= tot_in;
            wr_q   <= req_write;
            wop_q  <= req_wdata;
            rd_q   <= '0;
          end
        S_BUS:
          if (acked) begin
            addr_q <= addr_q + {{(ADDR_W-3){1'b0}}, n3};
            rem_q  <= rem_q - n3;
            if (!wr_q) rd_q <= rd_nx;
            st <= last ? S_IDLE : S_GAP;
          end
        default: st <= S_BUS;
      endcase
    end
  end

  assign ext_strobe = (st == S_BUS);
  assign ext_addr   = addr_q;
  assign ext_size   = rem_q[1:0];
  assign ext_write  = wr_q;
  assign ext_wdata  = wd;
  assign rsp_rdata  = rd_q;
  assign rsp_done   = done_q;
endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [1:0]        ext_size,
  input logic              ext_strobe,
  input logic [31:0]       ext_wdata,
  input logic [1:0]        ext_ack_n
);
  a_r2_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strobe && ext_ack_n == 2'b11 |=> ext_strobe && $stable(ext_addr)
      && $stable(ext_size) && $stable(ext_wdata) && !rsp_done);

  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strobe && ext_ack_n == 2'b11 |=> $stable(rsp_rdata));

  a_r10_strobe_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strobe && ext_ack_n != 2'b11 |=> !ext_strobe);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(ext_strobe && ext_ack_n != 2'b11) && !ext_strobe);
endmodule

bind bus_sizer bus_sizer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
  .ext_addr(ext_addr), .ext_size(ext_size), .ext_strobe(ext_strobe),
  .ext_wdata(ext_wdata), .ext_ack_n(ext_ack_n)
);

// File: tb/sim_bus_sizer.sv
module sim_bus_sizer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] rsp_rdata, ext_addr, ext_wdata;
  logic [31:0] ext_rdata = '0;
  logic        rsp_done, ext_strobe, ext_write;
  logic [1:0]  ext_size;
  logic [1:0]  ext_ack_n = 2'b11;

  bus_sizer u0 (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0]  mem [64];
  int          port_seq [8];
  logic [31:0] log_addr [8];
  logic [1:0]  log_size [8];
  int          ncyc = 0, waits = 0, wcnt = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected<=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      ext_ack_n = 2'b11; wcnt = 0;
    end else if (ext_ack_n != 2'b11) begin
      ext_ack_n = 2'b11;
    end else if (ext_strobe) begin
      if (wcnt < waits) wcnt++;
      else begin
        int p, a, rm, b, r, c, ws;
        logic [31:0] dat;
        wcnt = 0;
        p  = port_seq[ncyc % 8];
        a  = int'(ext_addr[5:0]);
        rm = (ext_size == 2'b00) ? 4 : int'(ext_size);
        log_addr[ncyc % 8] = ext_addr;
        log_size[ncyc % 8] = ext_size;
        ncyc++;
        b  = (p == 4) ? a % 4 : (p == 2) ? a % 2 : 0;
        r  = p - b;
        c  = (rm < r) ? rm : r;
        ws = a - b;
        dat = 32'hEEEE_EEEE;
        for (int l = 0; l < p; l++) dat[8*(3-l) +: 8] = mem[(ws + l) % 64];
        if (ext_write)
          for (int j = 0; j < c; j++) mem[(a + j) % 64] = ext_wdata[8*(3-b-j) +: 8];
        ext_rdata = dat;
        ext_ack_n = (p == 4) ? 2'b00 : (p == 2) ? 2'b01 : 2'b10;
      end
    end
  end

  task automatic run(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                     input logic [31:0] wd, input int w, input bit hold_other, output int lat);
    @(negedge clk);
    ncyc = 0; waits = w;
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        if (hold_other) begin req_addr = a ^ 32'h20; req_write = ~wr; end
        else req_valid = 1'b0;
      end
    end while (!rsp_done && lat < 200);
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] mword(input int a, input int nb);
    logic [31:0] v = '0;
    for (int i = 0; i < nb; i++) v = {v[23:0], mem[(a + i) % 64]};
    return v;
  endfunction

  task automatic t_reset();
    chk(!ext_strobe, "R1 strobe", 32'(ext_strobe), 0);
    chk(!rsp_done, "R1 done", 32'(rsp_done), 0);
    chk(rsp_rdata == 0, "R1 rdata", rsp_rdata, 0);
  endtask

  task automatic t_read32();
    int lat;
    run(32'h08, 2'b00, 0, 0, 0, 0, lat);
    chk(rsp_rdata == mword(8, 4), "R3 R7 rdata", rsp_rdata, mword(8, 4));
    chk(ncyc == 1, "R3 cycles", 32'(ncyc), 1);
    chk(lat == 2, "R3 latency", 32'(lat), 2);
  endtask

  task automatic t_read16();
    int lat;
    run(32'h10, 2'b00, 0, 0, 0, 0, lat);
    chk(rsp_rdata == mword(16, 4), "R4 rdata", rsp_rdata, mword(16, 4));
    chk(ncyc == 2 && log_addr[1] == 32'h12, "R4 second addr", log_addr[1], 32'h12);
    chk(log_size[0] == 2'b00 && log_size[1] == 2'b10, "R6 sizes", {log_size[0], log_size[1]}, 4'b0010);
    chk(lat == 4, "R4 latency", 32'(lat), 4);
  endtask

  task automatic t_read8_wait();
    int lat;
    run(32'h14, 2'b00, 0, 0, 1, 0, lat);
    chk(rsp_rdata == mword(20, 4), "R5 rdata", rsp_rdata, mword(20, 4));
    chk(ncyc == 4 && log_addr[3] == 32'h17, "R5 addr advance", log_addr[3], 32'h17);
    chk(log_size[1] == 2'b11 && log_size[3] == 2'b01, "R6 sizes three/one",
        {log_size[1], log_size[3]}, 4'b1101);
    chk(lat == 12, "R2 latency with wait", 32'(lat), 12);
  endtask

  task automatic t_misaligned();
    int lat;
    run(32'h05, 2'b00, 0, 0, 0, 0, lat);
    chk(rsp_rdata == mword(5, 4), "R9 rdata", rsp_rdata, mword(5, 4));
    chk(ncyc == 2 && log_addr[1] == 32'h08 && log_size[1] == 2'b01, "R9 split",
        log_addr[1], 32'h08);
  endtask

  task automatic t_mixed();
    int lat;
    port_seq[0] = 1; port_seq[1] = 2; port_seq[2] = 4;
    run(32'h30, 2'b00, 0, 0, 0, 0, lat);
    chk(rsp_rdata == mword(48, 4), "R11 rdata", rsp_rdata, mword(48, 4));
    chk(ncyc == 3 && log_addr[2] == 32'h32, "R11 third addr", log_addr[2], 32'h32);
  endtask

  task automatic t_byte();
    int lat;
    run(32'h3B, 2'b01, 0, 0, 0, 0, lat);
    chk(rsp_rdata == {24'h0, mem[59]}, "R7 byte right-justified", rsp_rdata, {24'h0, mem[59]});
  endtask

  task automatic t_writes();
    int lat;
    run(32'h21, 2'b10, 1, 32'h0000_A1B2, 0, 0, lat);
    chk({mem[33], mem[34]} == 16'hA1B2 && ncyc == 2, "R8 word to 8-bit", {mem[33], mem[34]}, 16'hA1B2);
    for (int i = 0; i < 8; i++) port_seq[i] = 2;
    run(32'h24, 2'b00, 1, 32'hC0C1_C2C3, 0, 0, lat);
    chk(mword(36, 4) == 32'hC0C1_C2C3, "R8 long to 16-bit", mword(36, 4), 32'hC0C1_C2C3);
    for (int i = 0; i < 8; i++) port_seq[i] = 4;
    run(32'h29, 2'b00, 1, 32'hD4D5_D6D7, 0, 0, lat);
    chk(mword(41, 4) == 32'hD4D5_D6D7 && ncyc == 2, "R9 R8 misaligned write", mword(41, 4), 32'hD4D5_D6D7);
  endtask

  task automatic t_overlap();
    int lat;
    bit quiet = 1;
    for (int i = 0; i < 8; i++) port_seq[i] = 1;
    run(32'h00, 2'b00, 0, 0, 0, 1, lat);
    chk(rsp_rdata == mword(0, 4) && log_addr[3] == 32'h03, "R12 first operand kept", log_addr[3], 32'h03);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (ext_strobe) quiet = 0;
    end
    chk(quiet, "R12 no new cycle", 32'(!quiet), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
    for (int i = 0; i < 8; i++) port_seq[i] = 4;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_read32();
    for (int i = 0; i < 8; i++) port_seq[i] = 2;
    t_read16();
    for (int i = 0; i < 8; i++) port_seq[i] = 1;
    t_read8_wait();
    for (int i = 0; i < 8; i++) port_seq[i] = 4;
    t_misaligned();
    t_mixed();
    for (int i = 0; i < 8; i++) port_seq[i] = 4;
    t_byte();
    for (int i = 0; i < 8; i++) port_seq[i] = 1;
    t_writes();
    t_overlap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule